// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, and moves a word between them in either direction. For each direction it can forward the live input bus or a word held in that direction's own capture register. The A-to-B register samples bus A on the rising edge of its own capture clock. The B-to-A register samples bus B on the rising edge of a second, independent capture clock.

An active-low enable and a direction input decide which bus, if any, is driven. Each bus is modelled as three signals: an input word, an output word and an output-enable flag. A surrounding pad ring or tristate wrapper therefore makes the physical bidirectional bus, and the design itself holds no tristate nets. The capture registers keep sampling while both outputs are disabled, so the block can serve as a holding register that is loaded first and driven out later.

A build-time parameter gives an inverting variant, in which every driven word is the bitwise complement of its source. The live/stored choice is purely combinational. The only storage is the two capture registers, so the register path is a single flop stage and fits easily in a 90 MHz capture clock budget.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a rising edge of `clk_ab` with `rst` low, the A-to-B register loads `a_in`. On a rising edge of `clk_ba` with `rst` low, the B-to-A register loads `b_in`. Neither register changes on the other register's clock.
- R2: With `sel_ab_stored` = 0, `b_out` follows `a_in` in the same cycle. With `sel_ba_stored` = 0, `a_out` follows `b_in` in the same cycle. No clock edge is needed in either case.
- R3: With `sel_ab_stored` = 1, `b_out` equals the A-to-B register. With `sel_ba_stored` = 1, `a_out` equals the B-to-A register. A change on the live input bus then leaves that output unchanged.
- R4: With `en_n` = 0, `dir_b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R5: With `en_n` = 1, both `a_oe` and `b_oe` are 0. `a_out` and `b_out` still carry their selected words, and `a_oe` and `b_oe` are never 1 together.
- R6: Both registers capture on their clocks exactly as in R1 while `en_n` = 1. A word captured while disabled appears on the output once the block is enabled with the stored select set.
- R7: With the parameter `INVERT` = 1, `a_out` and `b_out` are the bitwise complement of the word that R2 or R3 selects.
- R8: A rising capture clock edge with `rst` = 1 clears that direction's register to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst | input | 1 | Synchronous active-high clear of a register on its own capture clock |
| a_in | input | W | Word received from bus A |
| b_in | input | W | Word received from bus B |
| en_n | input | 1 | Active-low output enable for the pair of buses |
| dir_b | input | 1 | 1: drive bus B from the A side; 0: drive bus A from the B side |
| sel_ab_stored | input | 1 | 0: live `a_in` toward B; 1: stored A-to-B word |
| sel_ba_stored | input | 1 | 0: live `b_in` toward A; 1: stored B-to-A word |
| a_out | output | W | Word presented to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Word presented to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The capture properties assume that `a_in` and `b_in` are settled when their capture clock rises. They also assume that a capture clock rises only while `rst` is already at the level meant for that edge. The bench therefore changes data, selects and reset only between edges, with both capture clocks low. It then raises one clock for a 10 ns high phase, so every edge sees stable inputs. The drive-enable checks are combinational and hold for any input values. The bench sweeps all sixteen combinations of enable, direction and the two selects, so that every state of the drive decode is reached.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        TOWARD_A = 1'b0,
        TOWARD_B = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } oe_pair_t;

    localparam int NUM_DIRS = 2;
    localparam int IDX_A2B  = 0;
    localparam int IDX_B2A  = 1;

    function automatic oe_pair_t decode_drive(input logic enable_n, input xfer_dir_e dir);
        oe_pair_t r;
        r.drive_a = 1'b0;
        r.drive_b = 1'b0;
        if (!enable_n) begin
            if (dir == TOWARD_B) r.drive_b = 1'b1;
            else                 r.drive_a = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    input  logic         use_held,
    output logic [W-1:0] y
);
    logic [W-1:0] picked;

    always_comb picked = use_held ? held : live;

    generate
        if (INVERT) begin : g_inv
            assign y = ~picked;
        end else begin : g_true
            assign y = picked;
        end
    endgenerate
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import xcvr_pkg::*;
(
    input  logic     en_n,
    input  logic     dir_b,
    output oe_pair_t oe
);
    xfer_dir_e dir;

    always_comb begin
        dir = dir_b ? TOWARD_B : TOWARD_A;
        oe  = decode_drive(en_n, dir);
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         en_n,
    input  logic         dir_b,
    input  logic         sel_ab_stored,
    input  logic         sel_ba_stored,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [NUM_DIRS-1:0] cap_clk;
    logic [NUM_DIRS-1:0] use_held;
    logic [W-1:0]        src   [NUM_DIRS];
    logic [W-1:0]        held  [NUM_DIRS];
    logic [W-1:0]        route [NUM_DIRS];
    logic [W-1:0]        stored_ab;
    logic [W-1:0]        stored_ba;
    oe_pair_t            oe;

    assign cap_clk[IDX_A2B]  = clk_ab;
    assign cap_clk[IDX_B2A]  = clk_ba;
    assign use_held[IDX_A2B] = sel_ab_stored;
    assign use_held[IDX_B2A] = sel_ba_stored;
    assign src[IDX_A2B]      = a_in;
    assign src[IDX_B2A]      = b_in;

    generate
        for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
            xcvr_store #(.W(W)) u_store (
                .clk (cap_clk[d]),
                .rst (rst),
                .d   (src[d]),
                .q   (held[d])
            );
            xcvr_path #(.W(W), .INVERT(INVERT)) u_path (
                .live     (src[d]),
                .held     (held[d]),
                .use_held (use_held[d]),
                .y        (route[d])
            );
        end
    endgenerate

    xcvr_drive u_drive (
        .en_n  (en_n),
        .dir_b (dir_b),
        .oe    (oe)
    );

    assign stored_ab = held[IDX_A2B];
    assign stored_ba = held[IDX_B2A];
    assign b_out     = route[IDX_A2B];
    assign a_out     = route[IDX_B2A];
    assign a_oe      = oe.drive_a;
    assign b_oe      = oe.drive_b;
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         en_n,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] stored_ab,
    input logic [W-1:0] stored_ba
);
    // R1 / R6: each register holds the word seen at the previous edge of its own clock
    assert_capture_ab_R1: assert property (@(posedge clk_ab) disable iff (rst)
        1'b1 |=> (stored_ab == $past(a_in)));

    assert_capture_ba_R1: assert property (@(posedge clk_ba) disable iff (rst)
        1'b1 |=> (stored_ba == $past(b_in)));

    // R8: an edge taken in reset leaves the register cleared
    assert_clear_ab_R8: assert property (@(posedge clk_ab)
        $past(rst) |-> (stored_ab == '0));

    always_comb begin
        // R5: never both buses driven
        assert_single_driver_R5: assert (!(a_oe && b_oe));
        // R5: disabled means no drive
        assert_disabled_quiet_R5: assert (!(en_n && (a_oe || b_oe)));
        // R4: enabled means exactly one bus driven
        assert_enabled_one_R4: assert (en_n || (a_oe ^ b_oe));
    end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
    .clk_ab    (clk_ab),
    .clk_ba    (clk_ba),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .en_n      (en_n),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .stored_ab (stored_ab),
    .stored_ba (stored_ba)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
    localparam int W = 8;

    logic         sys_clk = 1'b0;
    logic         clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         en_n = 1'b1, dir_b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_out, b_out, ai_out, bi_out;
    logic         a_oe, b_oe, ai_oe, bi_oe;

    logic [W-1:0] m_ab = '0, m_ba = '0;
    int tests = 0, fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 sys_clk = ~sys_clk;

    bus_xcvr_reg #(.W(W), .INVERT(1'b0)) uut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .a_in(a_in), .b_in(b_in),
        .en_n(en_n), .dir_b(dir_b), .sel_ab_stored(sel_ab), .sel_ba_stored(sel_ba),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

    bus_xcvr_reg #(.W(W), .INVERT(1'b1)) uut_inv (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .a_in(a_in), .b_in(b_in),
        .en_n(en_n), .dir_b(dir_b), .sel_ab_stored(sel_ab), .sel_ba_stored(sel_ba),
        .a_out(ai_out), .a_oe(ai_oe), .b_out(bi_out), .b_oe(bi_oe));

    task automatic pulse_ab();
        #5 clk_ab = 1'b1;
        m_ab = rst ? '0 : a_in;
        #10 clk_ab = 1'b0;
        #5;
    endtask

    task automatic pulse_ba();
        #5 clk_ba = 1'b1;
        m_ba = rst ? '0 : b_in;
        #10 clk_ba = 1'b0;
        #5;
    endtask

    task automatic check_val(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [W-1:0] eb, ea;
        logic         eoa, eob;
        #1;
        eb  = sel_ab ? m_ab : a_in;
        ea  = sel_ba ? m_ba : b_in;
        eoa = !en_n && !dir_b;
        eob = !en_n && dir_b;
        check_val({tag, " b_out"}, b_out, eb);
        check_val({tag, " a_out"}, a_out, ea);
        check_val({tag, " a_oe"}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, eoa});
        check_val({tag, " b_oe"}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eob});
        check_val({tag, " R7 inv b_out"}, bi_out, ~eb);
        check_val({tag, " R7 inv a_out"}, ai_out, ~ea);
    endtask

    task automatic t_reset();
        rst = 1'b1; a_in = 8'hA5; b_in = 8'h3C;
        pulse_ab(); pulse_ba();
        rst = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; en_n = 1'b1;
        check_all("R8 reset clears both registers");
    endtask

    task automatic t_live();
        sel_ab = 1'b0; sel_ba = 1'b0; en_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            a_in = 8'h11 << i; b_in = 8'hF0 >> i; dir_b = i[0];
            check_all("R2 live pass-through");
        end
        a_in = 8'hFF; b_in = 8'h00;
        check_all("R2 live extremes");
    endtask

    task automatic t_capture();
        sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h5A; b_in = 8'hC3;
        pulse_ab();
        check_all("R1 A-to-B capture, B-to-A untouched");
        a_in = 8'h01; b_in = 8'h7E;
        pulse_ba();
        check_all("R1 B-to-A capture, A-to-B untouched");
    endtask

    task automatic t_stored_holds();
        sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h00; b_in = 8'hFF;
        check_all("R3 stored ignores live change 1");
        a_in = 8'h99; b_in = 8'h66;
        check_all("R3 stored ignores live change 2");
    endtask

    task automatic t_modes();
        a_in = 8'h2D; b_in = 8'hB4;
        for (int m = 0; m < 16; m++) begin
            en_n = m[3]; dir_b = m[2]; sel_ab = m[1]; sel_ba = m[0];
            check_all(m[3] ? "R5 disabled sweep" : "R4 enabled sweep");
        end
    endtask

    task automatic t_disabled_capture();
        en_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'hE7; b_in = 8'h18;
        pulse_ab(); pulse_ba();
        check_all("R6 capture while disabled");
        a_in = 8'h00; b_in = 8'h00; en_n = 1'b0; dir_b = 1'b1;
        check_all("R6 stored word driven to B after enable");
        dir_b = 1'b0;
        check_all("R6 stored word driven to A after enable");
    endtask

    task automatic t_reset_one();
        rst = 1'b1; a_in = 8'h77;
        pulse_ab();
        rst = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
        check_all("R8 reset on clk_ab clears only A-to-B");
    endtask

    initial begin
        while (!done) begin
            @(posedge sys_clk);
            cycles++;
            if (cycles > 20000) begin
                tests++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        #3;
        t_reset();
        t_live();
        t_capture();
        t_stored_holds();
        t_modes();
        t_disabled_capture();
        t_reset_one();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule